// File: doc/BRIEF.md
# AC-link Variable-Rate Slot Scheduler

This block decides which PCM output slots (slots 3 to 12) of each outgoing AC-link frame carry a new sample. A frame-level interface drives it: the receive side signals when slot 1 of an input frame has been fully received and hands over that 20-bit word. A second pulse marks the start of the next output frame. In variable-rate mode the codec uses slot 1 to ask for samples, one active-low flag per slot. The scheduler combines those flags with a slot-enable mask and fills the requested slots in the very next output frame. With variable-rate mode off, every enabled slot is filled in every frame.

Each slot has its own sample queue, loaded through a push port. When a frame starts, the scheduler pops one sample from each queue it must fill and presents the samples together with per-slot tag-valid bits for slot 0. A slot that must be filled but whose queue is empty goes out untagged, and a sticky underrun flag records the event.

Top module: `vrs_slot_sched`

## Requirements
- R1: While reset is high and after reset, `tx_frame_valid`, `tx_slot_valid` and `underrun` are all zero.
- R2: Output slot 3+i (index i, 0..9) is requested when bit 11-i of the slot-1 word is 0; bit 11 belongs to slot 3 and bit 2 to slot 12, and bits 19:12 and 1:0 are ignored.
- R3: With `vr_en` high at the slot-1 latch, slot index i is filled in the next frame only if it is requested and `slot_mask[i]` is 1.
- R4: With `vr_en` low at the slot-1 latch, every slot whose `slot_mask` bit is 1 is filled in the next frame, whatever the slot-1 word holds.
- R5: A `frame_start` pulse in cycle t makes `tx_frame_valid` high in cycle t+1 only, with the frame's tags and samples valid in that same cycle.
- R6: The fill decision is captured on the `rx_slot1_done` cycle; later changes to the slot-1 word, `vr_en` or `slot_mask` do not alter the frame that follows.
- R7: Each filled and tagged slot carries the oldest sample still queued for that slot, and the queue is consumed in push order.
- R8: `tx_slot_valid[i]` (tag for slot 3+i) is 1 only when slot index i is filled and its queue held a sample, and it is 0 outside the `tx_frame_valid` cycle.
- R9: A slot that must be filled while its queue is empty is sent with its tag at 0 and sets `underrun[i]`, which stays set until reset; no sample is consumed.
- R10: A codec that requests a slot at 44.1 kHz against a 48 kHz frame rate gets exactly 441 tagged frames for that slot out of 480.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vr_en | input | 1 | Variable-rate mode enable |
| slot_mask | input | 10 | Enabled output slots, bit i = slot 3+i |
| rx_slot1_word | input | 20 | Received slot-1 word of the current input frame |
| rx_slot1_done | input | 1 | Pulse: slot 1 fully received, latch decision |
| push_valid | input | 1 | Push a sample into a slot queue |
| push_slot | input | 4 | Target queue index (0..9 = slot 3..12) |
| push_data | input | 20 | Sample to push |
| frame_start | input | 1 | Pulse: next output frame begins |
| tx_frame_valid | output | 1 | Frame contents valid this cycle |
| tx_slot_valid | output | 10 | Slot-0 tag bits, bit i = slot 3+i |
| tx_samples | output | 200 | Samples, slot 3+i at bits i*20 +: 20 |
| underrun | output | 10 | Sticky per-slot underrun flags |

## Verification
The hardest case to reach is a slot that is requested and enabled while its queue is empty. That happens only after requests have drained a queue faster than it was refilled. The bench gets there by refilling queues before most frames but skipping the refill on some frames of a long sweep, while the request patterns keep draining. In every frame it also scrambles the slot-1 word, the mode bit and the mask right after the latch pulse, so any use of late values shows up in the tags. A Bresenham-style codec model issues 441 requests over 480 frames and checks the resulting tag count.

// File: rtl/vrs_pkg.sv
package vrs_pkg;
  parameter int NSLOT      = 10;  // output PCM slots 3..12
  parameter int FIRST_SLOT = 3;
  parameter int REQ_MSB    = 11;  // request bit for FIRST_SLOT
  parameter int REQ_LSB    = REQ_MSB - NSLOT + 1;
  parameter int SEL_W      = $clog2(NSLOT);
endpackage

// File: rtl/vrs_req_latch.sv
module vrs_req_latch
  import vrs_pkg::*;
#(
  parameter int SLOT_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vr_en,
  input  logic [NSLOT-1:0]  slot_mask,
  input  logic [SLOT_W-1:0] word,
  input  logic              done,
  output logic [NSLOT-1:0]  decision
);
  logic [NSLOT-1:0] req;
  logic             unused_bits;

  // index i <- bit REQ_MSB-i, active low
  for (genvar i = 0; i < NSLOT; i++) begin : g_map
    assign req[i] = ~word[REQ_MSB-i];
  end
  assign unused_bits = ^{word[SLOT_W-1:REQ_MSB+1], word[REQ_LSB-1:0]};

  always_ff @(posedge clk) begin
    if (rst)       decision <= '0;
    else if (done) decision <= vr_en ? (req & slot_mask) : slot_mask;
  end

  // R6
  decision_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(decision));
endmodule

// File: rtl/vrs_slot_fifo.sv
module vrs_slot_fifo #(
  parameter int W     = 20,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          full, do_push;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (pop)     rd_ptr <= nxt(rd_ptr);
      count <= count + CW'(do_push) - CW'(pop);
    end
  end

  // storage without reset so it maps to block RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
    if (pop)     rdata <= mem[rd_ptr];
  end

  // R9
  pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/vrs_slot_sched.sv
module vrs_slot_sched
  import vrs_pkg::*;
#(
  parameter int SLOT_W   = 20,
  parameter int SAMPLE_W = 20,
  parameter int DEPTH    = 8,
  parameter int PSEL_W   = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      vr_en,
  input  logic [NSLOT-1:0]          slot_mask,
  input  logic [SLOT_W-1:0]         rx_slot1_word,
  input  logic                      rx_slot1_done,
  input  logic                      push_valid,
  input  logic [PSEL_W-1:0]         push_slot,
  input  logic [SAMPLE_W-1:0]       push_data,
  input  logic                      frame_start,
  output logic                      tx_frame_valid,
  output logic [NSLOT-1:0]          tx_slot_valid,
  output logic [NSLOT*SAMPLE_W-1:0] tx_samples,
  output logic [NSLOT-1:0]          underrun
);
  logic [NSLOT-1:0] decision, empty_vec, pop_vec;

  vrs_req_latch #(.SLOT_W(SLOT_W)) u_latch (
    .clk(clk), .rst(rst), .vr_en(vr_en), .slot_mask(slot_mask),
    .word(rx_slot1_word), .done(rx_slot1_done), .decision(decision)
  );

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic push_i;
    assign push_i     = push_valid && (push_slot == PSEL_W'(i));
    assign pop_vec[i] = frame_start && decision[i] && !empty_vec[i];

    vrs_slot_fifo #(.W(SAMPLE_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst(rst), .push(push_i), .wdata(push_data),
      .pop(pop_vec[i]), .rdata(tx_samples[i*SAMPLE_W +: SAMPLE_W]),
      .empty(empty_vec[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_frame_valid <= 1'b0;
      tx_slot_valid  <= '0;
      underrun       <= '0;
    end else begin
      tx_frame_valid <= frame_start;
      tx_slot_valid  <= frame_start ? pop_vec : '0;
      if (frame_start) underrun <= underrun | (decision & empty_vec);
    end
  end

  // R8
  tag_needs_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_slot_valid != '0) |-> tx_frame_valid);
  // R3
  tag_within_decision_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> ((tx_slot_valid & ~$past(decision)) == '0));
  // R9
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((underrun & $past(underrun)) == $past(underrun)));
  // R9
  underrun_untagged_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((underrun & ~$past(underrun) & tx_slot_valid) == '0));
endmodule

// File: tb/tb_vrs_slot_sched.sv
`timescale 1ns/1ps
module tb_vrs_slot_sched;
  localparam int NS = 10, SW = 20, DW = 20;

  logic clk = 0, rst = 1;
  logic vr_en = 0, rx_slot1_done = 0, push_valid = 0, frame_start = 0;
  logic [NS-1:0] slot_mask = '0;
  logic [SW-1:0] rx_slot1_word = '0;
  logic [3:0] push_slot = '0;
  logic [DW-1:0] push_data = '0;
  logic tx_frame_valid;
  logic [NS-1:0] tx_slot_valid, underrun;
  logic [NS*DW-1:0] tx_samples;

  int total = 0, bad = 0;
  int wr_seq[NS], rd_seq[NS];
  logic [NS-1:0] exp_under = '0;
  int tag_count = 0;

  always #4 clk = ~clk;

  vrs_slot_sched dut (
    .clk(clk), .rst(rst), .vr_en(vr_en), .slot_mask(slot_mask),
    .rx_slot1_word(rx_slot1_word), .rx_slot1_done(rx_slot1_done),
    .push_valid(push_valid), .push_slot(push_slot), .push_data(push_data),
    .frame_start(frame_start), .tx_frame_valid(tx_frame_valid),
    .tx_slot_valid(tx_slot_valid), .tx_samples(tx_samples), .underrun(underrun)
  );

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic psh(input int s);
    push_valid = 1; push_slot = 4'(s);
    push_data = {4'(s), 16'(wr_seq[s])};
    wr_seq[s]++;
    @(negedge clk);
    push_valid = 0;
  endtask

  task automatic topup(input int target, input logic [NS-1:0] which);
    for (int s = 0; s < NS; s++)
      if (which[s]) while (wr_seq[s] - rd_seq[s] < target) psh(s);
  endtask

  // req: active-high request per slot index; other word bits from junk
  task automatic run_frame(input bit vr, input logic [NS-1:0] mask,
                           input logic [NS-1:0] req, input logic [SW-1:0] junk,
                           input string r);
    logic [SW-1:0] w;
    logic [NS-1:0] fill, expv;
    w = junk;
    for (int i = 0; i < NS; i++) w[11-i] = ~req[i];   // R2 mapping
    vr_en = vr; slot_mask = mask; rx_slot1_word = w; rx_slot1_done = 1;
    @(negedge clk);
    rx_slot1_done = 0;
    rx_slot1_word = ~w; vr_en = ~vr; slot_mask = ~mask;  // R6 late changes
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
    fill = vr ? (req & mask) : mask;
    expv = '0;
    for (int i = 0; i < NS; i++) begin
      if (fill[i] && wr_seq[i] > rd_seq[i]) expv[i] = 1;
      else if (fill[i]) exp_under[i] = 1;
    end
    chk(tx_frame_valid === 1'b1, "R5", 32'(tx_frame_valid), 1);
    chk(tx_slot_valid === expv, r, 32'(tx_slot_valid), 32'(expv));
    chk(underrun === exp_under, "R9", 32'(underrun), 32'(exp_under));
    for (int i = 0; i < NS; i++) if (expv[i]) begin
      chk(tx_samples[i*DW +: DW] === {4'(i), 16'(rd_seq[i])}, "R7",
          32'(tx_samples[i*DW +: DW]), 32'({4'(i), 16'(rd_seq[i])}));
      rd_seq[i]++;
    end
    if (tx_slot_valid[0]) tag_count++;
    @(negedge clk);
    chk(tx_frame_valid === 1'b0 && tx_slot_valid === '0, "R8",
        32'(tx_slot_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) begin wr_seq[s] = 0; rd_seq[s] = 0; end
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(tx_frame_valid === 0 && tx_slot_valid === '0 && underrun === '0,
        "R1", 32'(underrun), 0);
    rst = 0;
    @(negedge clk);
    chk(tx_frame_valid === 0 && tx_slot_valid === '0 && underrun === '0,
        "R1", 32'(tx_slot_valid), 0);

    // R4: fixed-rate mode fills every enabled slot regardless of slot 1
    topup(3, '1);
    run_frame(0, 10'h3FF, 10'h000, 20'h00000, "R4");
    topup(3, '1);
    run_frame(0, 10'h155, 10'h2AA, 20'hFFFFF, "R4");
    topup(3, '1);
    run_frame(0, 10'h0F0, 10'h3FF, 20'h5A5A5, "R4");

    // R2: each single request bit maps to its own slot
    for (int i = 0; i < NS; i++) begin
      topup(2, '1);
      run_frame(1, 10'h3FF, 10'(1 << i), 20'hF0F03, "R2");
    end

    // R3/R6/R9: sweep of requests and masks; some frames skip refill
    for (int k = 0; k < 256; k++) begin
      if (k % 16 != 7 && k % 16 != 8) topup(2, '1);
      run_frame(k % 5 != 0, (k % 2 == 0) ? 10'h3FF : 10'((k * 113) % 1024),
                10'((k * 37 + 5) % 1024), 20'((k * 7919) % 1048576), "R3");
    end

    // R9: drain slot index 5 then request it
    topup(2, 10'h3FF & ~10'h020);
    while (wr_seq[5] > rd_seq[5]) run_frame(1, 10'h020, 10'h020, 20'h0, "R9");
    run_frame(1, 10'h3FF, 10'h020, 20'h0, "R9");
    chk(underrun[5] === 1'b1, "R9", 32'(underrun), 32'(exp_under));
    psh(5);
    run_frame(1, 10'h3FF, 10'h000, 20'h0, "R9");
    chk(underrun[5] === 1'b1, "R9", 32'(underrun[5]), 1);

    // R10: 441 of 480 frames at 44.1 kHz over 48 kHz
    begin
      int acc;
      acc = 0;
      tag_count = 0;
      for (int f = 0; f < 480; f++) begin
        logic rq;
        acc += 441;
        rq = 0;
        if (acc >= 480) begin acc -= 480; rq = 1; end
        topup(2, 10'h001);
        run_frame(1, 10'h001, {9'h0, rq}, 20'h12345, "R10");
      end
      chk(tag_count == 441, "R10", 32'(tag_count), 441);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule